// File: doc/BRIEF.md
# Fixed-to-Floating-Point Element Converter

This block turns one fixed-point element into an IEEE-754 binary floating-point value of the same width: half (16 bits), single (32 bits) or double (64 bits). The element is read as signed two's complement or as unsigned, depending on a control bit. A runtime count of fractional bits scales the value, so the number converted is the integer divided by two to the power of that count.

The magnitude is normalised with a leading-zero count, and the exponent is derived from the position of its top bit less the fractional count. The result is rounded in one of four modes chosen by a control input. Results that are not exact raise an inexact indication. A trap-enable input then sends that indication either to a synchronous trap request or to a flag that sets sticky status further up.

The converter accepts one element per clock, and every output is registered once.

Top module: `fxp2fp_conv`

## Requirements
- R1: `fmt` selects the width: 00 is half (input bits 15:0), 01 is single (bits 31:0), and 10 or 11 is double (bits 63:0). Input bits above the selected width have no effect, and output bits above it are zero.
- R2: When `is_signed`=1 the element is two's complement and the sign of the result follows it. This includes the most negative value, whose magnitude is one bit wider than the positive range. When `is_signed`=0 the element is unsigned and the sign bit of the result is 0.
- R3: The converted value equals the element divided by 2^`frac_bits`, for `frac_bits` from 1 to the element width.
- R4: `rmode` 00 rounds to nearest with ties to even, 01 rounds toward plus infinity, 10 rounds toward minus infinity and 11 rounds toward zero.
- R5: `inexact` is 1 exactly when the result differs from the value in R3.
- R6: When rounding carries out of the mantissa, the exponent goes up by one and the mantissa becomes zero. For example, unsigned half 0xFFFF with `frac_bits`=1 under mode 00 gives 0x7800.
- R7: An element of zero gives +0.0 (all bits zero) with no flags, whether it is signed or unsigned.
- R8: When the result is inexact, `trap_en`=1 raises `trap_req` and `trap_en`=0 raises `flag_set`. Both stay 0 when the result is exact.
- R9: The outputs appear one clock after the inputs. An active-low asynchronous reset clears every output to zero.
- R10: Half results whose magnitude is below 2^-14 are encoded as subnormals (exponent field 0) and are always exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 64 | Fixed-point element, right-aligned |
| is_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| frac_bits | input | 7 | Number of fractional bits, 1 to the width |
| rmode | input | 2 | Rounding mode code |
| fmt | input | 2 | Width select |
| trap_en | input | 1 | Send inexact to the trap rather than to the flag |
| fp_out | output | 64 | Encoded float, right-aligned |
| inexact | output | 1 | Result was rounded |
| trap_req | output | 1 | Synchronous trap request |
| flag_set | output | 1 | Request to set the sticky inexact status |

## Verification
Every result, including `fp_out`, `inexact`, `trap_req` and `flag_set`, is due at the first rising edge after the inputs are applied. The bench changes inputs on the falling edge and samples one nanosecond after the next rising edge, so each vector takes one cycle and is compared in that cycle. Before that rising edge, the bench also checks that the output still holds the previous value. The bound checker uses one-cycle `$past` terms, and a primed flag keeps those terms from reaching back before reset.

// File: rtl/fxp2fp_conv.sv
module fxp2fp_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] din,
  input  logic        is_signed,
  input  logic [6:0]  frac_bits,
  input  logic [1:0]  rmode,
  input  logic [1:0]  fmt,
  input  logic        trap_en,
  output logic [63:0] fp_out,
  output logic        inexact,
  output logic        trap_req,
  output logic        flag_set
);

  function automatic logic [6:0] clz64(input logic [63:0] v);
    clz64 = 7'd64;
    for (int i = 0; i < 64; i++)
      if (v[i]) clz64 = 7'(63 - i);
  endfunction

  logic [63:0] ext, mag, norm, res;
  logic        neg, g, st, lsb, inc, sub, inx;
  logic [6:0]  lz;
  logic signed [8:0]  e_unb;
  logic signed [10:0] e_ext;
  logic [62:0] base, sum;
  logic [9:0]  sub_m;

  always_comb begin
    case (fmt)
      2'b00:   ext = {{48{is_signed & din[15]}}, din[15:0]};
      2'b01:   ext = {{32{is_signed & din[31]}}, din[31:0]};
      default: ext = din;
    endcase
  end

  assign neg   = is_signed & ext[63];
  assign mag   = neg ? (~ext + 64'd1) : ext;
  assign lz    = clz64(mag);
  assign norm  = mag << lz[5:0];
  assign e_unb = 9'sd63 - $signed({2'b00, lz}) - $signed({2'b00, frac_bits});
  assign e_ext = {{2{e_unb[8]}}, e_unb};
  assign sub   = (fmt == 2'b00) && (e_unb < -9'sd14);
  assign sub_m = 10'(mag << (7'd24 - frac_bits));

  // exponent is stored one low; the implicit leading one adds it back
  always_comb begin
    case (fmt)
      2'b00: begin
        base = (63'(5'(e_ext + 11'sd14)) << 10) + 63'(norm[63:53]);
        lsb  = norm[53];
        g    = norm[52];
        st   = |norm[51:0];
      end
      2'b01: begin
        base = (63'(8'(e_ext + 11'sd126)) << 23) + 63'(norm[63:40]);
        lsb  = norm[40];
        g    = norm[39];
        st   = |norm[38:0];
      end
      default: begin
        base = (63'(11'(e_ext + 11'sd1022)) << 52) + 63'(norm[63:11]);
        lsb  = norm[11];
        g    = norm[10];
        st   = |norm[9:0];
      end
    endcase
  end

  always_comb begin
    case (rmode)
      2'b00:   inc = g & (st | lsb);
      2'b01:   inc = ~neg & (g | st);
      2'b10:   inc = neg & (g | st);
      default: inc = 1'b0;
    endcase
  end

  assign sum = base + 63'(inc);

  always_comb begin
    if (mag == 64'd0) begin
      res = 64'd0;
      inx = 1'b0;
    end else if (sub) begin
      res = {48'd0, neg, 5'd0, sub_m};
      inx = 1'b0;
    end else begin
      inx = g | st;
      case (fmt)
        2'b00:   res = {48'd0, neg, sum[14:0]};
        2'b01:   res = {32'd0, neg, sum[30:0]};
        default: res = {neg, sum};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_out   <= '0;
      inexact  <= 1'b0;
      trap_req <= 1'b0;
      flag_set <= 1'b0;
    end else begin
      fp_out   <= res;
      inexact  <= inx;
      trap_req <= inx & trap_en;
      flag_set <= inx & ~trap_en;
    end
  end

endmodule

// File: rtl/fxp2fp_conv_chk.sv
module fxp2fp_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] din,
  input logic        is_signed,
  input logic [6:0]  frac_bits,
  input logic [1:0]  rmode,
  input logic [1:0]  fmt,
  input logic        trap_en,
  input logic [63:0] fp_out,
  input logic        inexact,
  input logic        trap_req,
  input logic        flag_set
);

  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(din == 64'd0) |-> (fp_out == 64'd0 && !inexact && !trap_req && !flag_set));

  p_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && inexact |-> (trap_req == $past(trap_en) && flag_set == !$past(trap_en)));

  p_exact_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inexact |-> (!trap_req && !flag_set));

  p_half_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(fmt == 2'b00) |-> fp_out[63:16] == 48'd0);

  p_single_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(fmt == 2'b01) |-> fp_out[63:32] == 32'd0);

  p_unsigned_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!is_signed) |->
      !(($past(fmt) == 2'b00) ? fp_out[15] : ($past(fmt) == 2'b01) ? fp_out[31] : fp_out[63]));

endmodule

bind fxp2fp_conv fxp2fp_conv_chk u_chk (.*);

// File: tb/fxp2fp_conv_bench.sv
module fxp2fp_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] din = '0;
  logic        is_signed = 1'b0;
  logic [6:0]  frac_bits = 7'd1;
  logic [1:0]  rmode = 2'b00;
  logic [1:0]  fmt = 2'b00;
  logic        trap_en = 1'b0;
  logic [63:0] fp_out;
  logic        inexact, trap_req, flag_set;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fxp2fp_conv u_fxp2fp_conv (.*);

  function automatic void ref_conv(input logic [63:0] d, input bit sg, input int fb,
                                   input logic [1:0] rm, input logic [1:0] f,
                                   output logic [63:0] r, output bit ix);
    int w, p, msb, e, sh;
    logic [64:0] el, m, sig, rem, hf;
    bit ng, up;
    w = (f == 0) ? 16 : (f == 1) ? 32 : 64;
    p = (f == 0) ? 11 : (f == 1) ? 24 : 53;
    el = '0;
    for (int i = 0; i < w; i++) el[i] = d[i];
    ng = sg && el[w-1];
    m = ng ? ((65'd1 << w) - el) : el;
    r = '0; ix = 0; up = 0; rem = '0; hf = '0;
    if (m == 0) return;
    msb = 0;
    for (int i = 0; i < 65; i++) if (m[i]) msb = i;
    e = msb - fb;
    if (f == 0 && e < -14) begin
      sig = m << (24 - fb);
      r = {48'd0, ng, 5'd0, sig[9:0]};
      return;
    end
    if (msb < p) sig = m << (p - 1 - msb);
    else begin
      sh = msb - p + 1;
      sig = m >> sh;
      rem = m & ((65'd1 << sh) - 65'd1);
      hf = 65'd1 << (sh - 1);
    end
    ix = (rem != 0);
    if (ix) begin
      case (rm)
        2'b00: up = (rem > hf) || (rem == hf && sig[0]);
        2'b01: up = !ng;
        2'b10: up = ng;
        default: up = 0;
      endcase
    end
    if (up) begin
      sig = sig + 65'd1;
      if (sig == (65'd1 << p)) begin sig = sig >> 1; e = e + 1; end
    end
    case (f)
      2'b00:   r = {48'd0, ng, 5'(e + 15), sig[9:0]};
      2'b01:   r = {32'd0, ng, 8'(e + 127), sig[22:0]};
      default: r = {ng, 11'(e + 1023), sig[51:0]};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] d, input bit sg, input int fb, input logic [1:0] rm,
                       input logic [1:0] f, input bit te);
    @(negedge clk);
    din = d; is_signed = sg; frac_bits = 7'(fb); rmode = rm; fmt = f; trap_en = te;
  endtask

  task automatic cmp_out(input logic [63:0] er, input bit ei, input bit te, input string req);
    check(fp_out == er, req, fp_out, er);
    check({inexact, trap_req, flag_set} == {ei, ei & te, ei & !te}, {req, " R5 R8 flags"},
          {61'd0, inexact, trap_req, flag_set}, {61'd0, ei, ei & te, ei & !te});
  endtask

  task automatic run(input logic [63:0] d, input bit sg, input int fb, input logic [1:0] rm,
                     input logic [1:0] f, input bit te, input string req);
    logic [63:0] er; bit ei;
    ref_conv(d, sg, fb, rm, f, er, ei);
    apply(d, sg, fb, rm, f, te);
    @(posedge clk); #1;
    cmp_out(er, ei, te, req);
  endtask

  task automatic direct(input logic [63:0] d, input bit sg, input int fb, input logic [1:0] rm,
                        input logic [1:0] f, input bit te, input logic [63:0] er, input bit ei,
                        input string req);
    apply(d, sg, fb, rm, f, te);
    @(posedge clk); #1;
    cmp_out(er, ei, te, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] held, d;
    int fb;
    void'($urandom(32'd2024));
    din = 64'hFFFF_FFFF_FFFF_FFFF; is_signed = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(fp_out == 64'd0 && !inexact && !trap_req && !flag_set, "R9 reset state",
          {fp_out[63:3], inexact, trap_req, flag_set}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    direct(64'd0, 1, 8, 2'b00, 2'b11, 0, 64'd0, 0, "R7 zero signed");
    direct(64'hABCD_0000_0000_0000, 0, 5, 2'b01, 2'b00, 1, 64'd0, 0, "R1 R7 upper bits ignored");
    direct(64'h8000_0000_0000_0000, 1, 64, 2'b00, 2'b10, 0, 64'hBFE0_0000_0000_0000, 0, "R2 most negative double");
    direct(64'h0000_0000_8000_0000, 1, 32, 2'b00, 2'b01, 0, 64'h0000_0000_BF00_0000, 0, "R2 most negative single");
    direct(64'h0000_0000_8000_0000, 0, 32, 2'b00, 2'b01, 0, 64'h0000_0000_3F00_0000, 0, "R2 unsigned single");
    direct(64'd3, 0, 1, 2'b00, 2'b10, 0, 64'h3FF8_0000_0000_0000, 0, "R3 scale 3/2");
    direct(64'hFFFF, 0, 1, 2'b00, 2'b00, 0, 64'h7800, 1, "R6 half carry");
    direct(64'hFFFF, 0, 1, 2'b11, 2'b00, 1, 64'h77FF, 1, "R4 half toward zero");
    direct(64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2'b00, 2'b10, 1, 64'h43E0_0000_0000_0000, 1, "R6 double carry");
    direct(64'h0801, 0, 1, 2'b00, 2'b00, 0, 64'h6400, 1, "R4 nearest tie even");
    direct(64'h0801, 0, 1, 2'b01, 2'b00, 1, 64'h6401, 1, "R4 toward plus");
    direct(64'h0801, 0, 1, 2'b10, 2'b00, 0, 64'h6400, 1, "R4 toward minus positive");
    direct(64'hF7FF, 1, 1, 2'b10, 2'b00, 0, 64'hE401, 1, "R4 toward minus negative");
    direct(64'hF7FF, 1, 1, 2'b01, 2'b00, 1, 64'hE400, 1, "R4 toward plus negative");
    direct(64'h0001, 0, 16, 2'b00, 2'b00, 0, 64'h0100, 0, "R10 half subnormal");
    direct(64'hFFFF, 1, 16, 2'b10, 2'b00, 0, 64'h8100, 0, "R10 negative subnormal");

    held = fp_out;
    apply(64'd5, 0, 2, 2'b00, 2'b01, 0);
    #1;
    check(fp_out == held, "R9 no early change", fp_out, held);
    @(posedge clk); #1;
    check(fp_out == 64'h0000_0000_3FA0_0000, "R9 one cycle latency", fp_out, 64'h3FA0_0000);

    for (int i = 0; i < 65536; i++)
      run({32'($urandom), 16'($urandom), 16'(i)}, ((i / 64) % 2) == 1, 1 + (i % 16),
          2'((i / 16) % 4), 2'b00, ((i / 128) % 2) == 1, "R1 R3 R4 half sweep");

    for (int i = 0; i < 30000; i++) begin
      logic [1:0] f;
      f = 2'($urandom_range(3));
      fb = (f == 2'b00) ? 1 + int'($urandom_range(15)) :
           (f == 2'b01) ? 1 + int'($urandom_range(31)) : 1 + int'($urandom_range(63));
      d = {32'($urandom), 32'($urandom)};
      if ((i % 7) == 0) d = d >> $urandom_range(63);
      run(d, 1'($urandom), fb, 2'($urandom), f, 1'($urandom), "R2 R3 R4 R5 random");
    end

    for (int i = 0; i < 300; i++) begin
      real rv;
      logic [63:0] er;
      d = {{14{1'b0}}, 50'({$urandom, $urandom})};
      if (i % 2 == 1) d = -d;
      fb = 1 + int'($urandom_range(63));
      rv = real'($signed(d)) / (2.0 ** fb);
      er = $realtobits(rv);
      direct(d, 1, fb, 2'($urandom), 2'b10, 0, er, 0, "R3 R5 exact double vs real");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule